// File: doc/BRIEF.md
# SPI Memory Command Front-End with Write Protection

This block is the slave side of a serial memory. A host selects it by pulling chip select low and then sends an instruction byte. Depending on that byte, the host follows with a 3-byte address and data bytes. The block performs reads and writes on an internal byte-wide synchronous RAM. It also keeps a small status register, and that register together with a write-protect pin decides whether any modifying instruction takes effect.

All pins are sampled in the block's own clock domain through synchronizers. The serial clock must therefore hold each level for at least four system clock cycles. Both clock polarities with sampling on the rising serial edge are accepted: idle-low (mode 0) and idle-high (mode 3). A hold pin can pause a transfer in the middle of a byte. The array holds 2^MEM_ABITS bytes; setting MEM_ABITS to 17 gives the full 128K x 8 array.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset the serial output enable is low, and the status register reads 0x00.
- R2: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. Opcode 0x05 shifts out the status byte, and repeats it for as long as the host keeps clocking. Status layout: bit 7 = protect-enable lock, bits 3:2 = block-protect code, bit 1 = write-enable flag, bit 0 = busy (always 0), other bits 0.
- R3: Opcode 0x02 is followed by three address bytes, most significant first, and then data bytes. The data bytes are stored at consecutive addresses. Address bits above MEM_ABITS are ignored.
- R4: Opcode 0x03 is followed by three address bytes and then returns bytes in a burst. The address increments after each byte and wraps from the last location to 0 until chip select rises.
- R5: An opcode 0x02 or 0x01 issued while the write-enable flag is 0 has no effect on memory or status.
- R6: The write-enable flag clears when chip select rises after a write that stored at least one full data byte, or after a status write that received its data byte.
- R7: Opcode 0x01 followed by one byte loads the lock bit from data bit 7 and the protect code from data bits 3:2. Other data bits are discarded.
- R8: While the write-protect pin is low and the lock bit is 1, a status write leaves the lock bit and the protect code unchanged.
- R9: Protect code 01 makes the top quarter of the array read-only, 10 the top half, and 11 the whole array. Code 00 protects nothing. Data sent to a protected location is dropped, and the address still advances.
- R10: Only the first byte after chip select falls is decoded as an opcode. Further bytes after 0x06 or 0x04 are ignored.
- R11: While the hold pin is low and the serial clock is low, the output enable is low and serial clock edges are ignored. The transfer resumes unchanged after hold returns high.
- R12: Input bits are taken on rising serial clock edges and output bits change on falling edges. This works with the clock idling low (mode 0) or idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| wp_n | input | 1 | Write-protect pin, active low |
| hold_n | input | 1 | Transfer pause, active low |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for sdo (low = high impedance) |

## Verification
Every serial edge reaches the logic two synchronizer stages plus one edge-detect register after the pin changes. A new output bit therefore appears on sdo about four system cycles after a falling serial edge. A read byte is fetched from RAM three cycles after the last address bit or the previous data bit. The bench holds each serial clock level for eight system cycles, so every result is due well inside that window. The monitor samples sdo at the next rising serial edge, and status and memory effects are read back only in a later chip-select frame.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OPC_SR_WRITE  = 8'h01;
  localparam logic [7:0] OPC_MEM_WRITE = 8'h02;
  localparam logic [7:0] OPC_MEM_READ  = 8'h03;
  localparam logic [7:0] OPC_WEN_CLR   = 8'h04;
  localparam logic [7:0] OPC_SR_READ   = 8'h05;
  localparam logic [7:0] OPC_WEN_SET   = 8'h06;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_ADDR,
    PH_DATA,
    PH_DROP
  } phase_t;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ,
    K_WRITE,
    K_SRRD,
    K_SRWR
  } cmd_t;

  function automatic logic [7:0] pack_status(input logic lock, input logic [1:0] prot,
                                             input logic wen);
    return {lock, 3'b000, prot, wen, 1'b0};
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic wp_n,
  input  logic hold_n,
  output logic rst_n_s,
  output logic cs_s,
  output logic sck_s,
  output logic sdi_s,
  output logic wp_s,
  output logic hold_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  localparam int NSIG = 5;
  // order {cs_n, wp_n, hold_n, sck, sdi}
  localparam logic [NSIG-1:0] IDLE = 5'b11100;

  logic [STAGES-1:0]           rst_pipe;
  logic [STAGES-1:0][NSIG-1:0] pipe;
  logic                        sck_p, cs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pipe <= {STAGES{IDLE}};
    else          pipe <= {pipe[STAGES-2:0], {cs_n, wp_n, hold_n, sck, sdi}};
  end

  assign {cs_s, wp_s, hold_s, sck_s, sdi_s} = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sck_p <= IDLE[1];
      cs_p  <= IDLE[4];
    end else begin
      sck_p <= sck_s;
      cs_p  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_p;
  assign sck_fall = ~sck_s & sck_p;
  assign cs_rise  = cs_s & ~cs_p;

endmodule

// File: rtl/spi_mem_prot.sv
module spi_mem_prot #(
  parameter int AW = 11
) (
  input  logic [1:0]    prot_code,
  input  logic [AW-1:0] addr,
  output logic          blocked
);
  logic top_half, top_qtr;

  assign top_half = addr[AW-1];
  assign top_qtr  = addr[AW-1] & addr[AW-2];

  always_comb begin
    unique case (prot_code)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = top_qtr;
      2'b10:   blocked = top_half;
      default: blocked = 1'b1;
    endcase
  end

endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_mem_pkg::*;
#(
  parameter int MEM_ABITS  = 11,
  parameter int ADDR_BYTES = 3,
  parameter int SYNC_STGS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic wp_n,
  input  logic hold_n,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW = MEM_ABITS;
  localparam logic [1:0] LAST_AB = 2'(ADDR_BYTES - 1);

  logic rst_n_s, cs_s, sck_s, sdi_s, wp_s, hold_s;
  logic sck_rise, sck_fall, cs_rise;

  spi_mem_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .wp_n(wp_n),
    .hold_n(hold_n), .rst_n_s(rst_n_s), .cs_s(cs_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .wp_s(wp_s), .hold_s(hold_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise)
  );

  // state registers
  phase_t        phase_q, phase_d;
  cmd_t          cmd_q, cmd_d;
  logic [2:0]    bit_cnt_q, bit_cnt_d;
  logic [6:0]    shreg_q, shreg_d;
  logic [1:0]    abyte_q, abyte_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    tx_q, tx_d;
  logic          sdo_q, sdo_d;
  logic          wen_q, wen_d;
  logic [1:0]    bp_q, bp_d;
  logic          lock_q, lock_d;
  logic          done_q, done_d;
  logic          hold_act_q, hold_act_d;
  logic          rd_pend_q, rd_pend_d;
  logic          ld_pend_q, ld_pend_d;

  // datapath
  logic          rise, fall, byte_end, blocked, sr_locked, is_rd;
  logic [7:0]    byte_in, sr_byte, ram_rdata;
  logic [AW+7:0] addr_cat;
  logic          ram_we, ram_re;

  spi_mem_prot #(.AW(AW)) i_prot (
    .prot_code(bp_q), .addr(addr_q), .blocked(blocked)
  );

  spi_mem_ram #(.AW(AW), .DW(8)) i_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(addr_q), .wdata(byte_in),
    .rdata(ram_rdata)
  );

  assign rise      = sck_rise & ~cs_s & ~hold_act_q;
  assign fall      = sck_fall & ~cs_s & ~hold_act_q;
  assign byte_end  = rise & (bit_cnt_q == 3'd7);
  assign byte_in   = {shreg_q, sdi_s};
  assign addr_cat  = {addr_q, byte_in};
  assign sr_byte   = pack_status(lock_q, bp_q, wen_q);
  assign sr_locked = lock_q & ~wp_s;
  assign is_rd     = (cmd_q == K_READ) | (cmd_q == K_SRRD);

  always_comb begin
    phase_d    = phase_q;
    cmd_d      = cmd_q;
    bit_cnt_d  = bit_cnt_q;
    shreg_d    = shreg_q;
    abyte_d    = abyte_q;
    addr_d     = addr_q;
    tx_d       = tx_q;
    sdo_d      = sdo_q;
    wen_d      = wen_q;
    bp_d       = bp_q;
    lock_d     = lock_q;
    done_d     = done_q;
    hold_act_d = hold_act_q;
    rd_pend_d  = 1'b0;
    ld_pend_d  = rd_pend_q;
    ram_we     = 1'b0;
    ram_re     = rd_pend_q;

    if (ld_pend_q) tx_d = ram_rdata;

    if (cs_s) begin
      phase_d    = PH_OPC;
      cmd_d      = K_NONE;
      bit_cnt_d  = 3'd0;
      abyte_d    = 2'd0;
      done_d     = 1'b0;
      hold_act_d = 1'b0;
      ld_pend_d  = 1'b0;
      ram_re     = 1'b0;
      if (cs_rise && done_q) wen_d = 1'b0;
    end else begin
      if (!sck_s) hold_act_d = ~hold_s;

      if (rise) begin
        shreg_d   = {shreg_q[5:0], sdi_s};
        bit_cnt_d = bit_cnt_q + 3'd1;
      end

      if (fall && phase_q == PH_DATA && is_rd) sdo_d = tx_q[3'd7 - bit_cnt_q];

      if (byte_end) begin
        unique case (phase_q)
          PH_OPC: begin
            phase_d = PH_DROP;
            unique case (byte_in)
              OPC_WEN_SET: wen_d = 1'b1;
              OPC_WEN_CLR: wen_d = 1'b0;
              OPC_SR_READ: begin
                cmd_d   = K_SRRD;
                phase_d = PH_DATA;
                tx_d    = sr_byte;
              end
              OPC_SR_WRITE: if (wen_q) begin
                cmd_d   = K_SRWR;
                phase_d = PH_DATA;
              end
              OPC_MEM_READ: begin
                cmd_d   = K_READ;
                phase_d = PH_ADDR;
              end
              OPC_MEM_WRITE: if (wen_q) begin
                cmd_d   = K_WRITE;
                phase_d = PH_ADDR;
              end
              default: ;
            endcase
          end
          PH_ADDR: begin
            addr_d  = addr_cat[AW-1:0];
            abyte_d = abyte_q + 2'd1;
            if (abyte_q == LAST_AB) begin
              phase_d   = PH_DATA;
              rd_pend_d = (cmd_q == K_READ);
            end
          end
          PH_DATA: begin
            unique case (cmd_q)
              K_SRWR: begin
                if (!sr_locked) begin
                  lock_d = byte_in[7];
                  bp_d   = byte_in[3:2];
                end
                done_d  = 1'b1;
                phase_d = PH_DROP;
              end
              K_WRITE: begin
                ram_we = ~blocked;
                addr_d = addr_q + 1'b1;
                done_d = 1'b1;
              end
              K_READ: begin
                addr_d    = addr_q + 1'b1;
                rd_pend_d = 1'b1;
              end
              K_SRRD:  tx_d = sr_byte;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q    <= PH_OPC;
      cmd_q      <= K_NONE;
      bit_cnt_q  <= 3'd0;
      shreg_q    <= 7'd0;
      abyte_q    <= 2'd0;
      addr_q     <= '0;
      tx_q       <= 8'd0;
      sdo_q      <= 1'b0;
      wen_q      <= 1'b0;
      bp_q       <= 2'b00;
      lock_q     <= 1'b0;
      done_q     <= 1'b0;
      hold_act_q <= 1'b0;
      rd_pend_q  <= 1'b0;
      ld_pend_q  <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cmd_q      <= cmd_d;
      bit_cnt_q  <= bit_cnt_d;
      shreg_q    <= shreg_d;
      abyte_q    <= abyte_d;
      addr_q     <= addr_d;
      tx_q       <= tx_d;
      sdo_q      <= sdo_d;
      wen_q      <= wen_d;
      bp_q       <= bp_d;
      lock_q     <= lock_d;
      done_q     <= done_d;
      hold_act_q <= hold_act_d;
      rd_pend_q  <= rd_pend_d;
      ld_pend_q  <= ld_pend_d;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = ~cs_s & (phase_q == PH_DATA) & is_rd & ~hold_act_q;

  // write enable must be gone in the cycle after a committed frame ends
  assert_wen_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cs_rise && done_q) |=> !wen_q);

  // a locked status register keeps its protect fields
  assert_sr_locked_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    sr_locked |=> ($stable(bp_q) && $stable(lock_q)));

  // array writes only happen while the write-enable flag is set
  assert_write_needs_wen_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ram_we |-> wen_q);

  // once past the opcode, a selected frame never decodes another opcode
  assert_opcode_once_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cs_s && phase_q != PH_OPC) |=> (phase_q != PH_OPC));

  // bit position frozen while held
  assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hold_act_q && !cs_s) |=> $stable(bit_cnt_q));

  // serial output only moves after a falling serial clock edge
  assert_sdo_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sck_fall |=> $stable(sdo_q));

endmodule

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int H     = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cs_n, sck, sdi, wp_n, hold_n;
  wire  sdo, sdo_oe;

  spi_mem_frontend #(.MEM_ABITS(AW)) i_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .wp_n(wp_n),
    .hold_n(hold_n), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] shadow [DEPTH];
  bit         m_wen = 0;
  logic [1:0] m_bp = 2'b00;
  bit         m_lock = 0;
  bit         mon_on = 0;
  bit         mode3 = 0;
  logic [7:0] mon_sh;
  int         mon_n = 0;
  bit         oe_bad = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic bit prot_hit(input int a);
    return (m_bp == 2'b11) || (m_bp == 2'b10 && a >= DEPTH / 2) ||
           (m_bp == 2'b01 && a >= (DEPTH * 3) / 4);
  endfunction

  function automatic logic [7:0] status_exp();
    return {m_lock, 3'b000, m_bp, m_wen, 1'b0};
  endfunction

  // monitor: collects read bytes at rising serial edges and scores them
  always @(posedge sck) begin
    if (mon_on && hold_n) begin
      mon_sh = {mon_sh[6:0], sdo};
      if (sdo_oe !== 1'b1) oe_bad = 1;
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          check(0, "unexpected byte", mon_sh, 8'h00);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(mon_sh === e && !oe_bad, t, mon_sh, e);
        end
        oe_bad = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic sel();
    sck = mode3;
    tick(H);
    cs_n = 0;
    tick(H);
  endtask

  task automatic desel();
    if (!mode3) sck = 0;
    tick(H);
    cs_n = 1;
    tick(2 * H);
  endtask

  task automatic xbyte(input logic [7:0] b, input bit hold_mid);
    for (int i = 7; i >= 0; i--) begin
      sck = 0;
      sdi = b[i];
      tick(H);
      if (hold_mid && i == 3) begin
        hold_n = 0;
        tick(H);
        check(sdo_oe === 1'b0, "R11 output released during hold", {7'd0, sdo_oe}, 8'h00);
        repeat (2) begin
          sck = 1; tick(H);
          sck = 0; tick(H);
        end
        hold_n = 1;
        tick(H);
      end
      sck = 1;
      tick(H);
    end
  endtask

  task automatic send_addr(input logic [23:0] a);
    xbyte(a[23:16], 0);
    xbyte(a[15:8], 0);
    xbyte(a[7:0], 0);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel();
    xbyte(op, 0);
    desel();
    if (op == 8'h06) m_wen = 1;
    if (op == 8'h04) m_wen = 0;
  endtask

  task automatic rd_sr(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(status_exp());
      tag_q.push_back(tag);
    end
    sel();
    xbyte(8'h05, 0);
    mon_on = 1;
    for (int i = 0; i < n; i++) xbyte(8'h00, 0);
    mon_on = 0;
    desel();
  endtask

  task automatic wr_sr(input logic [7:0] v);
    sel();
    xbyte(8'h01, 0);
    xbyte(v, 0);
    desel();
    if (m_wen) begin
      if (!(m_lock && !wp_n)) begin
        m_lock = v[7];
        m_bp   = v[3:2];
      end
      m_wen = 0;
    end
  endtask

  task automatic write_mem(input logic [23:0] a, input int n, input logic [7:0] base);
    sel();
    xbyte(8'h02, 0);
    send_addr(a);
    for (int i = 0; i < n; i++) xbyte(base + 8'(i), 0);
    desel();
    if (m_wen) begin
      for (int i = 0; i < n; i++) begin
        int p;
        p = (int'(a) + i) % DEPTH;
        if (!prot_hit(p)) shadow[p] = base + 8'(i);
      end
      m_wen = 0;
    end
  endtask

  task automatic read_mem(input logic [23:0] a, input int n, input string tag,
                          input bit hold);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(shadow[(int'(a) + i) % DEPTH]);
      tag_q.push_back(tag);
    end
    sel();
    xbyte(8'h03, 0);
    send_addr(a);
    mon_on = 1;
    for (int i = 0; i < n; i++) xbyte(8'h00, hold && i == 1);
    mon_on = 0;
    desel();
  endtask

  initial begin
    rst_n = 0; cs_n = 1; sck = 0; sdi = 0; wp_n = 1; hold_n = 1;
    tick(10);
    rst_n = 1;
    tick(10);

    check(sdo_oe === 1'b0, "R1 output enable low after reset", {7'd0, sdo_oe}, 8'h00);
    rd_sr(1, "R1 status after reset");

    cmd1(8'h06);
    rd_sr(1, "R2 write-enable set");
    write_mem(24'h000010, 4, 8'hA0);
    rd_sr(1, "R6 write-enable cleared after write");
    read_mem(24'h000010, 4, "R3 stored bytes", 0);
    write_mem(24'h000010, 2, 8'h55);
    read_mem(24'h000010, 4, "R5 write without enable ignored", 0);

    cmd1(8'h06);
    cmd1(8'h04);
    rd_sr(1, "R2 write-enable cleared by 0x04");

    // R10: second byte in the same frame is not an opcode
    sel();
    xbyte(8'h06, 0);
    xbyte(8'h04, 0);
    desel();
    m_wen = 1;
    rd_sr(2, "R10 trailing byte ignored");
    cmd1(8'h04);
    wr_sr(8'h8C);
    rd_sr(1, "R5 status write without enable ignored");

    cmd1(8'h06); write_mem(24'h000100, 2, 8'h11);
    cmd1(8'h06); write_mem(24'h000500, 2, 8'h22);
    cmd1(8'h06); write_mem(24'h0007F0, 2, 8'h33);

    cmd1(8'h06); write_mem(24'h0007FE, 3, 8'hC0);
    read_mem(24'h0007FE, 3, "R4 burst wraps to zero", 0);
    read_mem(24'h0007FF, 2, "R4 burst from last location", 0);

    cmd1(8'h06); write_mem(24'h01F805, 1, 8'h77);
    read_mem(24'h000005, 1, "R3 upper address bits ignored", 0);

    cmd1(8'h06);
    wr_sr(8'hFF);
    rd_sr(1, "R7 lock and protect loaded");
    cmd1(8'h06); write_mem(24'h000100, 1, 8'hEE);
    read_mem(24'h000100, 1, "R9 code 11 protects all", 0);

    wp_n = 0;
    cmd1(8'h06);
    wr_sr(8'h00);
    rd_sr(1, "R8 status locked by pin");
    wp_n = 1;
    cmd1(8'h06);
    wr_sr(8'h84);
    rd_sr(1, "R8 status writable with pin high");

    cmd1(8'h06); write_mem(24'h0007F0, 1, 8'h99);
    cmd1(8'h06); write_mem(24'h000500, 1, 8'h98);
    read_mem(24'h0007F0, 1, "R9 code 01 top quarter", 0);
    read_mem(24'h000500, 1, "R9 code 01 below quarter", 0);

    cmd1(8'h06);
    wr_sr(8'h08);
    rd_sr(1, "R7 protect code 10");
    cmd1(8'h06); write_mem(24'h000500, 1, 8'h97);
    cmd1(8'h06); write_mem(24'h000100, 1, 8'h96);
    read_mem(24'h000500, 1, "R9 code 10 top half", 0);
    read_mem(24'h000100, 1, "R9 code 10 lower half", 0);
    cmd1(8'h06);
    wr_sr(8'h00);

    mode3 = 1;
    sck = 1;
    tick(2 * H);
    cmd1(8'h06);
    write_mem(24'h000200, 3, 8'h40);
    read_mem(24'h000200, 3, "R12 idle-high clock", 0);
    rd_sr(1, "R12 status in idle-high clock");
    mode3 = 0;
    sck = 0;
    tick(2 * H);

    read_mem(24'h000200, 3, "R11 resume after hold", 1);

    tick(4 * H);
    check(exp_q.size() == 0, "R4 all expected bytes seen", 8'(exp_q.size()), 8'h00);
    check(sdo_oe === 1'b0, "R1 output enable low when deselected", {7'd0, sdo_oe}, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule